// File: doc/BRIEF.md
# Byte-Wide GPIO Port with Per-Pin Peripheral Direction Override

This block is an 8-pin general-purpose I/O port on a simple memory-mapped register bus. Software sets each pin's direction through a direction register and its output level through a port data register. A read-only input register returns the synchronized pad level of every pin, whatever the pin's direction. Comparing this value with the driven level lets software find an output that is shorted or overloaded.

Serial peripherals can take over pins. A fixed per-pin assignment mask picks the SPI pins, the SCI transmit pins and the SCI receive pins. While the SPI is enabled, its pins take their direction and output level from the SPI. An enabled SCI transmitter forces its pin to drive its serial data. An enabled SCI receiver forces its pin to be an input. On a pin claimed by both kinds of peripheral, the SCI wins over the SPI, and transmit wins over receive. When a channel is disabled, its pins follow the direction register again at once. The pad signals (output enable, output data, input) connect straight to the pad ring.

Top module: `gpio_ovr_port`

## Requirements
- R1: After synchronous reset, the direction register and the port data register both read 0x00, and with no peripheral enabled every pad_oe bit is 0.
- R2: The direction register at offset 0x037A can be read and written at any time. With no override on pin n, bit n = 1 drives pad_oe[n] high and bit n = 0 drives it low.
- R3: The port data register at offset 0x0378 can be read and written. On a pin with no override, pad_out[n] equals bit n of this register.
- R4: A read of offset 0x0379 returns pad_in after a two-flop synchronizer. A level applied before clock edge k is returned by reads after edge k+1, and the old level is still returned after edge k alone. This holds for every pin, including pins that are outputs.
- R5: A write to offset 0x0379 is ignored: the direction and data registers keep their values.
- R6: While spi_en is 1, each pin in SPI_MASK (default pins 0 to 3) takes pad_oe from spi_oe and pad_out from spi_dout, and the direction and data register bits for those pins have no effect.
- R7: While sci_tx_en is 1, each pin in TX_MASK (default pin 1) has pad_oe = 1 and pad_out = sci_tx_dout, whatever the direction bit says.
- R8: While sci_rx_en is 1, each pin in RX_MASK (default pin 0) that is not also an enabled transmit pin has pad_oe = 0, whatever the direction bit says.
- R9: On a pin claimed by both an SCI channel and the SPI, the enabled SCI override wins. Transmit wins over receive on a pin claimed by both SCI channels.
- R10: When a peripheral enable falls, the affected pins return to direction-register control at once, with no register write in between.
- R11: A read of any offset other than 0x0378, 0x0379 and 0x037A returns 0x00, and a write to such an offset changes no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_sel | input | 1 | Bus access strobe, one cycle per access |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 16 | Register offset |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, valid in the cycle of a read strobe, otherwise 0 |
| spi_en | input | 1 | SPI enabled |
| spi_oe | input | 8 | Direction requested by the SPI for each pin (1 = output) |
| spi_dout | input | 8 | Output level from the SPI for each pin |
| sci_tx_en | input | 1 | SCI transmit channel enabled |
| sci_tx_dout | input | 1 | Serial transmit data |
| sci_rx_en | input | 1 | SCI receive channel enabled |
| pad_in | input | 8 | Pad input levels (asynchronous) |
| pad_oe | output | 8 | Pad output enable per pin |
| pad_out | output | 8 | Pad output data per pin |

## Verification
The override mux is driven through a table of peripheral-enable combinations, each paired with different direction-register and SPI direction values. Direction-register-only rows show that the register reaches the pads. SPI-only rows separate SPI direction from register direction, because the two disagree on purpose. Rows with one SCI channel show the forcing against an opposite direction bit. Rows with SCI and SPI both enabled, on the shared pins 0 and 1, show the priority order. Directed tests cover the synchronizer latency cycle by cycle, reading the pad level back on a pin that is an output, writes to the read-only and unmapped offsets, and the return to register control when an enable drops.

// File: rtl/gpio_ovr_pkg.sv
package gpio_ovr_pkg;

    // Which agent owns a pin in the current cycle
    typedef enum logic [1:0] {
        SRC_PORT   = 2'd0,
        SRC_SPI    = 2'd1,
        SRC_SCI_TX = 2'd2,
        SRC_SCI_RX = 2'd3
    } pin_src_e;

    // Pad-side control for a single pin
    typedef struct packed {
        logic oe;
        logic dout;
    } pin_drive_t;

    // Register selected by a bus access
    typedef enum logic [1:0] {
        SEL_NONE = 2'd0,
        SEL_DAT  = 2'd1,
        SEL_IN   = 2'd2,
        SEL_DIR  = 2'd3
    } reg_sel_e;

    // Priority order: SCI transmit, SCI receive, SPI, then the port registers
    function automatic pin_src_e pick_src(input logic tx_hit,
                                          input logic rx_hit,
                                          input logic spi_hit);
        pin_src_e s;
        if (tx_hit)       s = SRC_SCI_TX;
        else if (rx_hit)  s = SRC_SCI_RX;
        else if (spi_hit) s = SRC_SPI;
        else              s = SRC_PORT;
        return s;
    endfunction

endpackage

// File: rtl/gpio_ovr_sync.sv
module gpio_ovr_sync #(
    parameter int W      = 8,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] stg [STAGES];

    always_ff @(posedge clk) begin
        if (rst) stg[0] <= '0;
        else     stg[0] <= d;
    end

    for (genvar s = 1; s < STAGES; s++) begin : g_stage
        always_ff @(posedge clk) begin
            if (rst) stg[s] <= '0;
            else     stg[s] <= stg[s-1];
        end
    end

    assign q = stg[STAGES-1];
endmodule

// File: rtl/gpio_ovr_regs.sv
module gpio_ovr_regs
    import gpio_ovr_pkg::*;
#(
    parameter int             W       = 8,
    parameter int             AW      = 16,
    parameter logic [AW-1:0]  OFF_DAT = 16'h0378,
    parameter logic [AW-1:0]  OFF_IN  = 16'h0379,
    parameter logic [AW-1:0]  OFF_DIR = 16'h037A
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          bus_sel,
    input  logic          bus_wr,
    input  logic [AW-1:0] bus_addr,
    input  logic [W-1:0]  bus_wdata,
    input  logic [W-1:0]  pin_sync,
    output logic [W-1:0]  ddr_q,
    output logic [W-1:0]  dat_q,
    output logic [W-1:0]  bus_rdata
);
    reg_sel_e sel;

    always_comb begin
        if      (bus_addr == OFF_DAT) sel = SEL_DAT;
        else if (bus_addr == OFF_IN)  sel = SEL_IN;
        else if (bus_addr == OFF_DIR) sel = SEL_DIR;
        else                          sel = SEL_NONE;
    end

    // The input offset has no write path: its contents come from the pads
    always_ff @(posedge clk) begin
        if (rst) begin
            ddr_q <= '0;
            dat_q <= '0;
        end else if (bus_sel && bus_wr) begin
            if (sel == SEL_DIR) ddr_q <= bus_wdata;
            if (sel == SEL_DAT) dat_q <= bus_wdata;
        end
    end

    always_comb begin
        bus_rdata = '0;
        if (bus_sel && !bus_wr) begin
            unique case (sel)
                SEL_DAT:  bus_rdata = dat_q;
                SEL_IN:   bus_rdata = pin_sync;
                SEL_DIR:  bus_rdata = ddr_q;
                default:  bus_rdata = '0;
            endcase
        end
    end
endmodule

// File: rtl/gpio_ovr_mux.sv
module gpio_ovr_mux
    import gpio_ovr_pkg::*;
#(
    parameter int           W        = 8,
    parameter logic [W-1:0] SPI_MASK = 8'h0F,
    parameter logic [W-1:0] TX_MASK  = 8'h02,
    parameter logic [W-1:0] RX_MASK  = 8'h01
) (
    input  logic [W-1:0] ddr_q,
    input  logic [W-1:0] dat_q,
    input  logic         spi_en,
    input  logic [W-1:0] spi_oe,
    input  logic [W-1:0] spi_dout,
    input  logic         sci_tx_en,
    input  logic         sci_tx_dout,
    input  logic         sci_rx_en,
    output logic [W-1:0] pad_oe,
    output logic [W-1:0] pad_out
);
    for (genvar i = 0; i < W; i++) begin : g_pin
        pin_src_e   src;
        pin_drive_t drv;

        assign src = pick_src(sci_tx_en & TX_MASK[i],
                              sci_rx_en & RX_MASK[i],
                              spi_en    & SPI_MASK[i]);

        always_comb begin
            unique case (src)
                SRC_SCI_TX: drv = '{oe: 1'b1,      dout: sci_tx_dout};
                SRC_SCI_RX: drv = '{oe: 1'b0,      dout: dat_q[i]};
                SRC_SPI:    drv = '{oe: spi_oe[i], dout: spi_dout[i]};
                default:    drv = '{oe: ddr_q[i],  dout: dat_q[i]};
            endcase
        end

        assign pad_oe[i]  = drv.oe;
        assign pad_out[i] = drv.dout;
    end
endmodule

// File: rtl/gpio_ovr_port.sv
module gpio_ovr_port
    import gpio_ovr_pkg::*;
#(
    parameter int             W        = 8,
    parameter int             AW       = 16,
    parameter int             SYNC_N   = 2,
    parameter logic [AW-1:0]  OFF_DAT  = 16'h0378,
    parameter logic [AW-1:0]  OFF_IN   = 16'h0379,
    parameter logic [AW-1:0]  OFF_DIR  = 16'h037A,
    parameter logic [W-1:0]   SPI_MASK = 8'h0F,
    parameter logic [W-1:0]   TX_MASK  = 8'h02,
    parameter logic [W-1:0]   RX_MASK  = 8'h01
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          bus_sel,
    input  logic          bus_wr,
    input  logic [AW-1:0] bus_addr,
    input  logic [W-1:0]  bus_wdata,
    output logic [W-1:0]  bus_rdata,
    input  logic          spi_en,
    input  logic [W-1:0]  spi_oe,
    input  logic [W-1:0]  spi_dout,
    input  logic          sci_tx_en,
    input  logic          sci_tx_dout,
    input  logic          sci_rx_en,
    input  logic [W-1:0]  pad_in,
    output logic [W-1:0]  pad_oe,
    output logic [W-1:0]  pad_out
);
    logic [W-1:0] pin_sync;
    logic [W-1:0] ddr_q;
    logic [W-1:0] dat_q;

    gpio_ovr_sync #(.W(W), .STAGES(SYNC_N)) u_sync (
        .clk (clk),
        .rst (rst),
        .d   (pad_in),
        .q   (pin_sync)
    );

    gpio_ovr_regs #(
        .W(W), .AW(AW), .OFF_DAT(OFF_DAT), .OFF_IN(OFF_IN), .OFF_DIR(OFF_DIR)
    ) u_regs (
        .clk       (clk),
        .rst       (rst),
        .bus_sel   (bus_sel),
        .bus_wr    (bus_wr),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .pin_sync  (pin_sync),
        .ddr_q     (ddr_q),
        .dat_q     (dat_q),
        .bus_rdata (bus_rdata)
    );

    gpio_ovr_mux #(
        .W(W), .SPI_MASK(SPI_MASK), .TX_MASK(TX_MASK), .RX_MASK(RX_MASK)
    ) u_mux (
        .ddr_q       (ddr_q),
        .dat_q       (dat_q),
        .spi_en      (spi_en),
        .spi_oe      (spi_oe),
        .spi_dout    (spi_dout),
        .sci_tx_en   (sci_tx_en),
        .sci_tx_dout (sci_tx_dout),
        .sci_rx_en   (sci_rx_en),
        .pad_oe      (pad_oe),
        .pad_out     (pad_out)
    );
endmodule

// File: rtl/gpio_ovr_chk.sv
module gpio_ovr_chk #(
    parameter int             W        = 8,
    parameter int             AW       = 16,
    parameter logic [AW-1:0]  OFF_DAT  = 16'h0378,
    parameter logic [AW-1:0]  OFF_IN   = 16'h0379,
    parameter logic [AW-1:0]  OFF_DIR  = 16'h037A,
    parameter logic [W-1:0]   SPI_MASK = 8'h0F,
    parameter logic [W-1:0]   TX_MASK  = 8'h02,
    parameter logic [W-1:0]   RX_MASK  = 8'h01
) (
    input logic          clk,
    input logic          rst,
    input logic          bus_sel,
    input logic          bus_wr,
    input logic [AW-1:0] bus_addr,
    input logic [W-1:0]  bus_rdata,
    input logic          spi_en,
    input logic          sci_tx_en,
    input logic          sci_rx_en,
    input logic [W-1:0]  pad_in,
    input logic [W-1:0]  pad_oe,
    input logic [W-1:0]  ddr_q,
    input logic [W-1:0]  dat_q
);
    localparam logic [W-1:0] ANY_MASK = SPI_MASK | TX_MASK | RX_MASK;

    logic [1:0] since_rst;
    always_ff @(posedge clk) begin
        if (rst)                  since_rst <= '0;
        else if (since_rst != 2'd3) since_rst <= since_rst + 2'd1;
    end

    logic unmapped;
    assign unmapped = (bus_addr != OFF_DAT) && (bus_addr != OFF_IN) && (bus_addr != OFF_DIR);

    // R1
    reset_clear_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(rst) |-> (ddr_q == '0 && dat_q == '0));

    // R2
    dir_follow_chk: assert property (@(posedge clk) disable iff (rst)
        ((pad_oe & ~ANY_MASK) == (ddr_q & ~ANY_MASK)));

    // R4
    input_sync_chk: assert property (@(posedge clk) disable iff (rst)
        (since_rst == 2'd3 && bus_sel && !bus_wr && bus_addr == OFF_IN)
        |-> (bus_rdata == $past(pad_in, 2)));

    // R5
    ro_write_chk: assert property (@(posedge clk) disable iff (rst)
        (bus_sel && bus_wr && bus_addr == OFF_IN) |=> ($stable(ddr_q) && $stable(dat_q)));

    // R7
    tx_force_chk: assert property (@(posedge clk) disable iff (rst)
        sci_tx_en |-> ((pad_oe & TX_MASK) == TX_MASK));

    // R8
    rx_force_chk: assert property (@(posedge clk) disable iff (rst)
        sci_rx_en |-> ((pad_oe & RX_MASK & ~(sci_tx_en ? TX_MASK : '0)) == '0));

    // R10
    idle_revert_chk: assert property (@(posedge clk) disable iff (rst)
        (!spi_en && !sci_tx_en && !sci_rx_en) |-> (pad_oe == ddr_q));

    // R11
    unmapped_rd_chk: assert property (@(posedge clk) disable iff (rst)
        (bus_sel && !bus_wr && unmapped) |-> (bus_rdata == '0));

    // R11
    unmapped_wr_chk: assert property (@(posedge clk) disable iff (rst)
        (bus_sel && bus_wr && unmapped) |=> ($stable(ddr_q) && $stable(dat_q)));
endmodule

bind gpio_ovr_port gpio_ovr_chk #(
    .W(W), .AW(AW), .OFF_DAT(OFF_DAT), .OFF_IN(OFF_IN), .OFF_DIR(OFF_DIR),
    .SPI_MASK(SPI_MASK), .TX_MASK(TX_MASK), .RX_MASK(RX_MASK)
) u_chk (
    .clk       (clk),
    .rst       (rst),
    .bus_sel   (bus_sel),
    .bus_wr    (bus_wr),
    .bus_addr  (bus_addr),
    .bus_rdata (bus_rdata),
    .spi_en    (spi_en),
    .sci_tx_en (sci_tx_en),
    .sci_rx_en (sci_rx_en),
    .pad_in    (pad_in),
    .pad_oe    (pad_oe),
    .ddr_q     (ddr_q),
    .dat_q     (dat_q)
);

// File: tb/sim_gpio_ovr_port.sv
module sim_gpio_ovr_port;

    localparam logic [15:0] A_DAT = 16'h0378;
    localparam logic [15:0] A_IN  = 16'h0379;
    localparam logic [15:0] A_DIR = 16'h037A;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        bus_sel = 1'b0;
    logic        bus_wr = 1'b0;
    logic [15:0] bus_addr = '0;
    logic [7:0]  bus_wdata = '0;
    logic [7:0]  bus_rdata;
    logic        spi_en = 1'b0;
    logic [7:0]  spi_oe = '0;
    logic [7:0]  spi_dout = '0;
    logic        sci_tx_en = 1'b0;
    logic        sci_tx_dout = 1'b0;
    logic        sci_rx_en = 1'b0;
    logic [7:0]  pad_in = '0;
    logic [7:0]  pad_oe;
    logic [7:0]  pad_out;

    int n_checks = 0;
    int n_fail   = 0;

    always #5 clk = ~clk;

    gpio_ovr_port u0 (
        .clk(clk), .rst(rst),
        .bus_sel(bus_sel), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .spi_en(spi_en), .spi_oe(spi_oe), .spi_dout(spi_dout),
        .sci_tx_en(sci_tx_en), .sci_tx_dout(sci_tx_dout), .sci_rx_en(sci_rx_en),
        .pad_in(pad_in), .pad_oe(pad_oe), .pad_out(pad_out)
    );

    // Override table: {spi_en, tx_en, rx_en, ddr, spi_oe, expected pad_oe, requirement}
    typedef struct packed {
        logic       spi;
        logic       tx;
        logic       rx;
        logic [7:0] ddr;
        logic [7:0] soe;
        logic [7:0] exp_oe;
        logic [7:0] req;
    } vec_t;

    localparam int NV = 11;
    localparam vec_t VT [NV] = '{
        '{1'b0, 1'b0, 1'b0, 8'hA5, 8'h00, 8'hA5, 8'd2 },  // R2 register only
        '{1'b1, 1'b0, 1'b0, 8'hFF, 8'h00, 8'hF0, 8'd6 },  // R6 SPI forces inputs
        '{1'b1, 1'b0, 1'b0, 8'h00, 8'h0F, 8'h0F, 8'd6 },  // R6 SPI forces outputs
        '{1'b1, 1'b0, 1'b0, 8'h00, 8'h05, 8'h05, 8'd6 },  // R6 mixed SPI direction
        '{1'b0, 1'b1, 1'b0, 8'h00, 8'h00, 8'h02, 8'd7 },  // R7 tx pin driven
        '{1'b0, 1'b0, 1'b1, 8'hFF, 8'h00, 8'hFE, 8'd8 },  // R8 rx pin released
        '{1'b1, 1'b1, 1'b0, 8'h00, 8'h00, 8'h02, 8'd9 },  // R9 tx beats SPI
        '{1'b1, 1'b0, 1'b1, 8'h00, 8'h0F, 8'h0E, 8'd9 },  // R9 rx beats SPI
        '{1'b0, 1'b1, 1'b1, 8'h00, 8'h00, 8'h02, 8'd8 },  // R8 both SCI channels
        '{1'b1, 1'b1, 1'b1, 8'hF0, 8'h0C, 8'hFE, 8'd9 },  // R9 all enabled
        '{1'b0, 1'b0, 1'b0, 8'h3C, 8'hFF, 8'h3C, 8'd10}   // R10 all released
    };

    task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%02h expected=%02h", tag, act, exp);
        end
    endtask

    task automatic bus_write(input logic [15:0] a, input logic [7:0] d);
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_sel = 1'b0; bus_wr = 1'b0;
    endtask

    task automatic bus_read(input logic [15:0] a, output logic [7:0] d);
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
        #1 d = bus_rdata;
        bus_sel = 1'b0;
    endtask

    task automatic finish_run();
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    endtask

    initial begin
        #200000;
        n_checks++; n_fail++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        logic [7:0] rd;
        repeat (3) @(negedge clk);
        rst = 1'b0;

        // R1 reset state
        check("R1 pad_oe after reset", pad_oe, 8'h00);
        bus_read(A_DIR, rd); check("R1 direction reg reset", rd, 8'h00);
        bus_read(A_DAT, rd); check("R1 data reg reset", rd, 8'h00);

        // Override table walk
        for (int i = 0; i < NV; i++) begin
            bus_write(A_DIR, VT[i].ddr);
            @(negedge clk);
            spi_en = VT[i].spi; sci_tx_en = VT[i].tx; sci_rx_en = VT[i].rx;
            spi_oe = VT[i].soe;
            #1 check($sformatf("R%0d table row %0d pad_oe", VT[i].req, i), pad_oe, VT[i].exp_oe);
        end

        // R2 direction readback
        bus_write(A_DIR, 8'h69);
        bus_read(A_DIR, rd); check("R2 direction readback", rd, 8'h69);

        // R3 data register and pad_out on unclaimed pins
        bus_write(A_DAT, 8'h5A);
        bus_read(A_DAT, rd); check("R3 data readback", rd, 8'h5A);
        #1 check("R3 pad_out follows data", pad_out, 8'h5A);

        // R6 SPI output data on its pins, data reg elsewhere
        @(negedge clk);
        spi_en = 1'b1; spi_dout = 8'hF3;
        #1 check("R6 pad_out with SPI", pad_out, 8'h53);

        // R7 tx data beats SPI data on pin 1 (R9)
        @(negedge clk);
        sci_tx_en = 1'b1; sci_tx_dout = 1'b0;
        #1 check("R7 R9 pad_out tx low", pad_out, 8'h51);
        @(negedge clk);
        sci_tx_dout = 1'b1;
        #1 check("R7 pad_out tx high", pad_out, 8'h53);

        // R10 dropping enables reverts to registers
        @(negedge clk);
        spi_en = 1'b0; sci_tx_en = 1'b0;
        #1 check("R10 pad_out reverts", pad_out, 8'h5A);
        check("R10 pad_oe reverts", pad_oe, 8'h69);

        // R4 synchronizer latency; pins 0,3,5,6 are outputs here
        @(negedge clk);
        pad_in = 8'hC3;
        bus_read(A_IN, rd); check("R4 after one edge old level", rd, 8'h00);
        bus_read(A_IN, rd); check("R4 after two edges new level", rd, 8'hC3);
        @(negedge clk);
        pad_in = 8'h3C;
        repeat (2) @(negedge clk);
        bus_read(A_IN, rd); check("R4 pad level on output pins", rd, 8'h3C);

        // R5 write to input offset ignored
        bus_write(A_IN, 8'hFF);
        bus_read(A_DIR, rd); check("R5 direction unchanged", rd, 8'h69);
        bus_read(A_DAT, rd); check("R5 data unchanged", rd, 8'h5A);
        #1 check("R5 pad_oe unchanged", pad_oe, 8'h69);

        // R11 unmapped offsets
        bus_write(16'h037B, 8'hFF);
        bus_write(16'h0000, 8'h00);
        bus_read(A_DIR, rd); check("R11 direction unchanged", rd, 8'h69);
        bus_read(A_DAT, rd); check("R11 data unchanged", rd, 8'h5A);
        bus_read(16'h037B, rd); check("R11 unmapped read", rd, 8'h00);
        bus_read(16'h0377, rd); check("R11 unmapped read low", rd, 8'h00);

        // R1 reset again clears registers
        @(negedge clk); rst = 1'b1;
        @(negedge clk); rst = 1'b0;
        #1 check("R1 pad_oe after second reset", pad_oe, 8'h00);
        check("R1 pad_out after second reset", pad_out, 8'h00);

        finish_run();
    end
endmodule